// File: doc/BRIEF.md
# NAND Flash Device Command Logic

This block is a synthesizable device-side model of an 8-bit multiplexed NAND flash port. A host drives chip select, a command-latch flag, an address-latch flag, a write strobe, a read strobe, a spare-hide input and a write-protect input. The block returns an 8-bit output byte, an output-enable flag and a ready flag. All pins are sampled on the system clock. A rising write strobe with chip select low captures one byte. A falling read strobe with chip select low delivers one byte.

The block decodes the command set and gathers the address cycles. It tracks a page-register pointer that can aim at the low half, the high half or the spare bytes of a 528-byte page. It runs page reads with automatic advance to the next page, serial data loading followed by a program confirm, a two-step block erase, status polling, identification read and a soft reset. The cell store is a small array of pages that resets to FFh. Page load, program, erase and reset each keep the device busy for a configurable number of clock cycles.

Top module: `nand_cmd_ctrl`

## Requirements
- R1: A byte on io_in is taken on a rising edge of we_n while ce_n is low. With cle high and ale low it is a command. With ale high and cle low it is an address. With both low it is a data byte.
- R2: Read and load addresses take three cycles: column byte, then row bits 7:0, then row bits 14:8. Command 00h starts the column at 0 plus the byte. Command 01h starts it at 256 plus the byte. Command 50h starts it at 512 plus the low four bits.
- R3: Once an operation has used the 01h pointer (its third address cycle has been taken), the pointer reverts to the low half. A later read or load that issues no pointer command then addresses columns 0–255.
- R4: In spare mode, column bits 7:4 are ignored. Command 50h has no effect while spare_hide is high. The spare pointer stays in force across program operations.
- R5: Each falling edge of re_n in read mode puts the byte at the current column on io_out and advances the column by one. io_oe is high only while ce_n and re_n are both low.
- R6: The last column is 511 when spare_hide is high and 527 otherwise. Reading it moves to the next row, drops ready for a page load, and restarts at column 512 in spare mode and at column 0 otherwise.
- R7: The sequence 80h, three address cycles, data bytes, 10h programs a page by ANDing the loaded bytes into the cells; bytes that were not loaded stay as they are. A 10h with no data loaded since the 80h does not start a program.
- R8: The sequence 60h, row bits 7:0, row bits 14:8, D0h erases a block to FFh. Row bits 4:0 do not select the block.
- R9: While ready is low, only 70h and FFh are accepted. Every other command, address or data byte is dropped.
- R10: The status byte has bit 0 as fail (1) or pass (0), bit 6 as ready, and bit 7 as the level of wp_n. All other bits are 0. After reset with wp_n high it reads C0h.
- R11: Command 90h followed by address 00h makes the next two reads return the manufacturer code (default ECh) and then the device code (default 73h).
- R12: A program or erase that finishes while wp_n is low leaves the cells unchanged and sets the fail bit.
- R13: Command FFh is accepted at any time. It aborts a program or erase in flight, clears the fail bit and returns the pointer to the low half, then releases ready after its own busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Marks the strobed byte as a command |
| ale | input | 1 | Marks the strobed byte as an address |
| we_n | input | 1 | Write strobe; a byte is taken on its rising edge |
| re_n | input | 1 | Read strobe; a byte is delivered on its falling edge |
| spare_hide | input | 1 | High hides the spare bytes from reads and loads |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Command, address or data byte from the host |
| io_out | output | 8 | Byte delivered to the host |
| io_oe | output | 1 | Output drive enable |
| ready | output | 1 | High when no internal operation is running |

## Verification
Two functions collide when a soft reset arrives while a program is still counting down. The restart of the busy timer for the reset and the pending commit of the program compete for the same state. The bench provokes this by issuing FFh a few cycles after a 10h confirm that targets the spare bytes. It then judges the outcome at the ports: the spare byte still reads FFh, a read sent with no pointer command lands in the low half, and the status byte reads C0h with the fail bit cleared. A second overlap is a status poll made during a program. The bench expects 80h while busy and C0h once ready returns, and it checks that an identification command issued in between had no effect.

// File: rtl/nand_pkg.sv
// Shared types and codes for the NAND command logic.
// Assumes one page of 512 main bytes plus 16 spare bytes.
package nand_pkg;
    localparam int PAGE_BYTES = 528;
    localparam int MAIN_BYTES = 512;
    localparam int HALF_BYTES = 256;
    localparam int COL_W      = 10;
    localparam int ROW_W      = 15;

    localparam logic [7:0] CMD_RD_LOW   = 8'h00;
    localparam logic [7:0] CMD_RD_HIGH  = 8'h01;
    localparam logic [7:0] CMD_RD_SPARE = 8'h50;
    localparam logic [7:0] CMD_LOAD     = 8'h80;
    localparam logic [7:0] CMD_PROG     = 8'h10;
    localparam logic [7:0] CMD_ERASE    = 8'h60;
    localparam logic [7:0] CMD_ERASE_GO = 8'hD0;
    localparam logic [7:0] CMD_STATUS   = 8'h70;
    localparam logic [7:0] CMD_IDENT    = 8'h90;
    localparam logic [7:0] CMD_RESET    = 8'hFF;

    typedef enum logic [2:0] {MD_IDLE, MD_READ, MD_PROG, MD_ERASE, MD_STATUS, MD_IDENT} mode_e;
    typedef enum logic [1:0] {PT_LOW, PT_HIGH, PT_SPARE} ptr_e;
    typedef enum logic [2:0] {OP_NONE, OP_LOAD, OP_PROG, OP_ERASE, OP_RESET} op_e;
endpackage

// File: rtl/nand_strobe_edge.sv
// Turns the sampled strobes into single-cycle events.
// Assumes the strobes are already synchronous to clk; events need ce_n low.
module nand_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic re_n,
    output logic we_rise,
    output logic re_fall
);
    logic we_d, re_d;

    // Hold the previous level of both strobes (idle high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_d <= 1'b1;
            re_d <= 1'b1;
        end else begin
            we_d <= we_n;
            re_d <= re_n;
        end
    end

    assign we_rise = !we_d && we_n && !ce_n;
    assign re_fall = re_d && !re_n && !ce_n;
endmodule

// File: rtl/nand_busy_timer.sv
// Down-counter that models an internal operation time.
// Assumes len is at least 1; a new start reloads the counter (abort).
module nand_busy_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] len,
    output logic         busy,
    output logic         done
);
    logic [W-1:0] cnt;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (start)        cnt <= len;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == W'(1)) && !start;
endmodule

// File: rtl/nand_cell_array.sv
// Cell store of PAGES pages plus one page buffer for program data.
// Program ANDs the buffer into a page; erase sets every page to FFh.
// Assumes PAGES is a power of two.
module nand_cell_array
    import nand_pkg::*;
#(
    parameter int PAGES = 4,
    parameter int PG_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_clear,
    input  logic             buf_wr,
    input  logic [COL_W-1:0] buf_col,
    input  logic [7:0]       buf_data,
    input  logic             commit,
    input  logic             erase_all,
    input  logic [PG_W-1:0]  page_sel,
    input  logic [COL_W-1:0] rd_col,
    output logic [7:0]       rd_byte
);
    logic [7:0] cells [PAGES][PAGE_BYTES];
    logic [7:0] pbuf  [PAGE_BYTES];

    // Cell contents: erased at reset, cleared bits on commit, FFh on erase.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_all) begin
            for (int p = 0; p < PAGES; p++)
                for (int c = 0; c < PAGE_BYTES; c++)
                    cells[p][c] <= 8'hFF;
        end else if (commit) begin
            for (int c = 0; c < PAGE_BYTES; c++)
                cells[page_sel][c] <= cells[page_sel][c] & pbuf[c];
        end
    end

    // Page buffer: filled with FFh on a new load, then written byte by byte.
    always_ff @(posedge clk) begin
        if (!rst_n || buf_clear) begin
            for (int c = 0; c < PAGE_BYTES; c++)
                pbuf[c] <= 8'hFF;
        end else if (buf_wr) begin
            pbuf[buf_col] <= buf_data;
        end
    end

    assign rd_byte = (rd_col < COL_W'(PAGE_BYTES)) ? cells[page_sel][rd_col] : 8'hFF;
endmodule

// File: rtl/nand_cmd_ctrl.sv
// Command, address and pointer state machine of a NAND flash device model.
// Assumes strobes are synchronous to clk and spaced by at least one cycle.
// Rows map onto the cell array modulo PAGES; an erase clears the whole array.
module nand_cmd_ctrl
    import nand_pkg::*;
#(
    parameter int         PAGES    = 4,
    parameter int         TMR_W    = 16,
    parameter int         T_LOAD   = 20,
    parameter int         T_PROG   = 60,
    parameter int         T_ERASE  = 100,
    parameter int         T_RESET  = 10,
    parameter logic [7:0] MFR_CODE = 8'hEC,
    parameter logic [7:0] DEV_CODE = 8'h73
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic       spare_hide,
    input  logic       wp_n,
    input  logic [7:0] io_in,
    output logic [7:0] io_out,
    output logic       io_oe,
    output logic       ready
);
    localparam int PG_W = $clog2(PAGES);
    localparam logic [COL_W-1:0] LAST_MAIN  = COL_W'(MAIN_BYTES - 1);
    localparam logic [COL_W-1:0] LAST_SPARE = COL_W'(PAGE_BYTES - 1);

    mode_e            mode_q;
    ptr_e             ptr_q;
    op_e              op_q;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;
    logic [1:0]       acnt_q;
    logic             loaded_q, fail_q, id_sel_q, tstart_q;
    logic [TMR_W-1:0] tlen_q;
    logic [7:0]       dout_q;

    logic we_rise, re_fall, tmr_busy, tmr_done, busy_any;
    logic is_cmd, is_addr, is_data, data_ok, buf_wr, buf_clear;
    logic arr_commit, arr_erase;
    logic [7:0] rd_byte, status_byte;
    logic [1:0] acnt_eff;
    logic [COL_W-1:0] last_col, wrap_col, col_start;

    nand_strobe_edge u_edge (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .re_n(re_n),
        .we_rise(we_rise), .re_fall(re_fall));

    nand_busy_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tstart_q), .len(tlen_q),
        .busy(tmr_busy), .done(tmr_done));

    nand_cell_array #(.PAGES(PAGES), .PG_W(PG_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .buf_clear(buf_clear), .buf_wr(buf_wr),
        .buf_col(col_q), .buf_data(io_in), .commit(arr_commit),
        .erase_all(arr_erase), .page_sel(row_q[PG_W-1:0]), .rd_col(col_q),
        .rd_byte(rd_byte));

    // Classify the strobed byte and derive pointer-dependent columns.
    always_comb begin
        busy_any    = tmr_busy || tstart_q;
        is_cmd      = we_rise && cle && !ale;
        is_addr     = we_rise && ale && !cle && !busy_any;
        is_data     = we_rise && !ale && !cle && !busy_any;
        data_ok     = is_data && (mode_q == MD_PROG) && (acnt_q == 2'd3);
        buf_wr      = data_ok && (col_q < (spare_hide ? COL_W'(MAIN_BYTES) : COL_W'(PAGE_BYTES)));
        buf_clear   = is_cmd && !busy_any && (io_in == CMD_LOAD);
        arr_commit  = tmr_done && (op_q == OP_PROG) && wp_n;
        arr_erase   = tmr_done && (op_q == OP_ERASE) && wp_n;
        status_byte = {wp_n, !busy_any, 5'b0, fail_q};
        last_col    = spare_hide ? LAST_MAIN : LAST_SPARE;
        wrap_col    = (ptr_q == PT_SPARE) ? COL_W'(MAIN_BYTES) : '0;
        acnt_eff    = (mode_q == MD_READ && acnt_q == 2'd3) ? 2'd0 : acnt_q;
        case (ptr_q)
            PT_HIGH:  col_start = COL_W'(HALF_BYTES) + {2'b00, io_in};
            PT_SPARE: col_start = COL_W'(MAIN_BYTES) + {6'd0, io_in[3:0]};
            default:  col_start = {2'b00, io_in};
        endcase
    end

    // Main sequencer: completion, commands, addresses, data and read strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MD_READ;  ptr_q <= PT_LOW;  op_q <= OP_NONE;
            col_q <= '0;  row_q <= '0;  acnt_q <= '0;
            loaded_q <= 1'b0;  fail_q <= 1'b0;  id_sel_q <= 1'b0;
            tstart_q <= 1'b0;  tlen_q <= '0;  dout_q <= '0;
        end else begin
            tstart_q <= 1'b0;
            if (tmr_done) begin
                op_q <= OP_NONE;
                if (op_q == OP_PROG || op_q == OP_ERASE) fail_q <= !wp_n;
            end
            if (is_cmd && io_in == CMD_RESET) begin
                op_q <= OP_RESET;  tstart_q <= 1'b1;  tlen_q <= TMR_W'(T_RESET);
                mode_q <= MD_READ;  ptr_q <= PT_LOW;  fail_q <= 1'b0;
                acnt_q <= '0;  loaded_q <= 1'b0;
            end else if (is_cmd && io_in == CMD_STATUS) begin
                mode_q <= MD_STATUS;
            end else if (is_cmd && !busy_any) begin
                case (io_in)
                    CMD_RD_LOW:   begin ptr_q <= PT_LOW;  mode_q <= MD_READ; acnt_q <= '0; end
                    CMD_RD_HIGH:  begin ptr_q <= PT_HIGH; mode_q <= MD_READ; acnt_q <= '0; end
                    CMD_RD_SPARE: if (!spare_hide) begin
                                      ptr_q <= PT_SPARE; mode_q <= MD_READ; acnt_q <= '0;
                                  end
                    CMD_LOAD:     begin mode_q <= MD_PROG; acnt_q <= '0; loaded_q <= 1'b0; end
                    CMD_PROG:     if (mode_q == MD_PROG && loaded_q) begin
                                      op_q <= OP_PROG; tstart_q <= 1'b1;
                                      tlen_q <= TMR_W'(T_PROG); mode_q <= MD_IDLE;
                                  end
                    CMD_ERASE:    begin mode_q <= MD_ERASE; acnt_q <= '0; end
                    CMD_ERASE_GO: if (mode_q == MD_ERASE && acnt_q >= 2'd2) begin
                                      op_q <= OP_ERASE; tstart_q <= 1'b1;
                                      tlen_q <= TMR_W'(T_ERASE); mode_q <= MD_IDLE;
                                  end
                    CMD_IDENT:    begin mode_q <= MD_IDENT; id_sel_q <= 1'b0; end
                    default:      ;
                endcase
            end
            if (is_addr) begin
                if (acnt_eff != 2'd3) acnt_q <= acnt_eff + 2'd1;
                if (mode_q == MD_READ || mode_q == MD_PROG) begin
                    case (acnt_eff)
                        2'd0: col_q <= col_start;
                        2'd1: row_q[7:0] <= io_in;
                        2'd2: begin
                            row_q[14:8] <= io_in[6:0];
                            if (ptr_q == PT_HIGH) ptr_q <= PT_LOW;
                            if (mode_q == MD_READ) begin
                                op_q <= OP_LOAD; tstart_q <= 1'b1; tlen_q <= TMR_W'(T_LOAD);
                            end
                        end
                        default: ;
                    endcase
                end else if (mode_q == MD_ERASE) begin
                    if (acnt_q == 2'd0) row_q[7:0] <= io_in;
                    else if (acnt_q == 2'd1) row_q[14:8] <= io_in[6:0];
                end else if (mode_q == MD_IDENT) begin
                    id_sel_q <= 1'b0;
                end
            end
            if (data_ok) begin
                loaded_q <= 1'b1;
                col_q    <= col_q + 1'b1;
            end
            if (re_fall) begin
                if (mode_q == MD_STATUS) begin
                    dout_q <= status_byte;
                end else if (mode_q == MD_IDENT) begin
                    dout_q   <= id_sel_q ? DEV_CODE : MFR_CODE;
                    id_sel_q <= 1'b1;
                end else if (mode_q == MD_READ && !busy_any) begin
                    dout_q <= rd_byte;
                    if (col_q >= last_col) begin
                        col_q <= wrap_col;  row_q <= row_q + 1'b1;
                        op_q <= OP_LOAD;  tstart_q <= 1'b1;  tlen_q <= TMR_W'(T_LOAD);
                    end else begin
                        col_q <= col_q + 1'b1;
                    end
                end
            end
        end
    end

    assign io_out = dout_q;
    assign io_oe  = !ce_n && !re_n;
    assign ready  = !busy_any;
endmodule

// File: rtl/nand_cmd_ctrl_chk.sv
// Temporal checks on the NAND command logic, bound into the top module.
module nand_cmd_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ready,
    input logic [7:0] io_out,
    input logic       re_fall,
    input logic       we_rise,
    input logic       tmr_done,
    input logic       commit,
    input logic       erase
);
    // Output byte only moves after an accepted read strobe.
    assert_out_moves_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(re_fall) |-> $stable(io_out));

    // Busy is entered only in reaction to a host strobe.
    assert_busy_from_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(we_rise || re_fall));

    // Ready comes back only after the timer reports completion.
    assert_ready_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(tmr_done));

    // Cells are programmed only at the end of a busy period.
    assert_commit_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !ready);

    // Cells are erased only at the end of a busy period.
    assert_erase_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        erase |-> !ready);
endmodule

bind nand_cmd_ctrl nand_cmd_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .io_out(io_out),
    .re_fall(re_fall), .we_rise(we_rise), .tmr_done(tmr_done),
    .commit(arr_commit), .erase(arr_erase));

// File: tb/nand_cmd_ctrl_tb.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor compares them.
module nand_cmd_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n, ce_n, cle, ale, we_n, re_n, spare_hide, wp_n;
    logic [7:0] io_in, io_out;
    logic io_oe, ready;
    int n_chk = 0, n_err = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];
    event mon_ev;

    always #4 clk = ~clk;

    nand_cmd_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .spare_hide(spare_hide), .wp_n(wp_n),
        .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .ready(ready));

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Monitor: pop one expected byte per delivered read.
    initial begin
        forever begin
            @(mon_ev);
            if (exp_q.size() == 0) chk(io_out, 8'hxx, "scoreboard empty");
            else chk(io_out, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic wr(input logic c, input logic a, input logic [7:0] d);
        @(negedge clk); cle = c; ale = a; io_in = d; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); cle = 1'b0; ale = 1'b0;
    endtask
    task automatic cmd(input logic [7:0] d); wr(1'b1, 1'b0, d); endtask
    task automatic adr(input logic [7:0] d); wr(1'b0, 1'b1, d); endtask
    task automatic dat(input logic [7:0] d); wr(1'b0, 1'b0, d); endtask

    task automatic rd_expect(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); re_n = 1'b0;
        @(negedge clk); -> mon_ev;
        @(negedge clk); re_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_ready();
        repeat (3) @(negedge clk);
        while (!ready) @(negedge clk);
    endtask

    task automatic rd_addr(input logic [7:0] c, input logic [7:0] col, input logic [7:0] row);
        cmd(c); adr(col); adr(row); adr(8'h00); wait_ready();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        report();
    end

    initial begin
        rst_n = 1'b0; ce_n = 1'b0; cle = 1'b0; ale = 1'b0; we_n = 1'b1; re_n = 1'b1;
        spare_hide = 1'b1; wp_n = 1'b1; io_in = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({7'd0, ready}, 8'h01, "R10 ready after reset");
        chk({7'd0, io_oe}, 8'h00, "R5 no drive when idle");
        cmd(8'h70); rd_expect(8'hC0, "R10 status after reset");

        // R1 R7: program three data bytes into row 1 from column 5
        cmd(8'h00); cmd(8'h80); adr(8'h05); adr(8'h01); adr(8'h00);
        dat(8'h12); dat(8'h34); dat(8'h56); cmd(8'h10);
        repeat (2) @(negedge clk);
        chk({7'd0, ready}, 8'h00, "R7 busy during program");
        wait_ready();
        cmd(8'h70); rd_expect(8'hC0, "R7 program pass");
        rd_addr(8'h00, 8'h04, 8'h01);
        rd_expect(8'hFF, "R2 unloaded byte");
        rd_expect(8'h12, "R1 data byte 0");
        rd_expect(8'h34, "R5 column advance");
        rd_expect(8'h56, "R7 data byte 2");
        @(negedge clk); re_n = 1'b0;
        @(negedge clk); chk({7'd0, io_oe}, 8'h01, "R5 drive while strobe low");
        re_n = 1'b1; @(negedge clk);

        // R7: confirm without data does not start
        cmd(8'h80); adr(8'h20); adr(8'h01); adr(8'h00); cmd(8'h10);
        repeat (4) @(negedge clk);
        chk({7'd0, ready}, 8'h01, "R7 confirm without data ignored");

        // R2 R3: high-half load, then fallback on the next load
        cmd(8'h01); cmd(8'h80); adr(8'h02); adr(8'h01); adr(8'h00); dat(8'hAB); cmd(8'h10);
        wait_ready();
        cmd(8'h80); adr(8'h09); adr(8'h02); adr(8'h00); dat(8'h77); cmd(8'h10);
        wait_ready();
        rd_addr(8'h01, 8'h02, 8'h01); rd_expect(8'hAB, "R2 high half column");
        rd_addr(8'h00, 8'h09, 8'h02); rd_expect(8'h77, "R3 load fell back to low half");
        rd_addr(8'h01, 8'h09, 8'h02); rd_expect(8'hFF, "R3 high half untouched");
        adr(8'h09); adr(8'h02); adr(8'h00); wait_ready();
        rd_expect(8'h77, "R3 read fell back to low half");

        // R4 R6: spare pointer
        spare_hide = 1'b0;
        cmd(8'h50); cmd(8'h80); adr(8'hF3); adr(8'h01); adr(8'h00); dat(8'h5A); cmd(8'h10);
        wait_ready();
        cmd(8'h80); adr(8'h00); adr(8'h02); adr(8'h00); dat(8'h3C); cmd(8'h10);
        wait_ready();
        rd_addr(8'h50, 8'hE3, 8'h01); rd_expect(8'h5A, "R4 spare high column bits ignored");
        rd_addr(8'h50, 8'h0F, 8'h01); rd_expect(8'hFF, "R6 last spare column");
        chk({7'd0, ready}, 8'h00, "R6 busy loading next page");
        wait_ready();
        rd_expect(8'h3C, "R6 next page restarts at 512");

        // R4: spare command ignored while spare_hide high
        cmd(8'h00); spare_hide = 1'b1;
        rd_addr(8'h50, 8'h03, 8'h01); rd_expect(8'hFF, "R4 spare command ignored");

        // R6: last main column with spare hidden
        cmd(8'h00); cmd(8'h80); adr(8'h00); adr(8'h03); adr(8'h00); dat(8'h81); cmd(8'h10);
        wait_ready();
        rd_addr(8'h01, 8'hFF, 8'h02); rd_expect(8'hFF, "R6 last main column");
        wait_ready();
        rd_expect(8'h81, "R6 wrap to column 0 of next row");

        // R9 R10: status while busy, other command dropped
        cmd(8'h00); cmd(8'h80); adr(8'h01); adr(8'h00); adr(8'h00); dat(8'h0F); cmd(8'h10);
        repeat (3) @(negedge clk);
        cmd(8'h70); rd_expect(8'h80, "R10 status while busy");
        cmd(8'h90);
        wait_ready();
        rd_expect(8'hC0, "R9 identify command dropped while busy");

        // R8: erase with low row bits set
        cmd(8'h60); adr(8'h1F); adr(8'h00); cmd(8'hD0);
        wait_ready();
        cmd(8'h70); rd_expect(8'hC0, "R8 erase pass");
        rd_addr(8'h00, 8'h05, 8'h01); rd_expect(8'hFF, "R8 row 1 erased");
        rd_addr(8'h00, 8'h00, 8'h03); rd_expect(8'hFF, "R8 row 3 erased");

        // Known byte for later pointer check
        cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h00); dat(8'h99); cmd(8'h10);
        wait_ready();

        // R12: write protect
        wp_n = 1'b0;
        cmd(8'h00); cmd(8'h80); adr(8'h02); adr(8'h00); adr(8'h00); dat(8'h00); cmd(8'h10);
        wait_ready();
        cmd(8'h70); rd_expect(8'h41, "R12 program fails when protected");
        rd_addr(8'h00, 8'h02, 8'h00); rd_expect(8'hFF, "R12 cells kept");
        cmd(8'h60); adr(8'h00); adr(8'h00); cmd(8'hD0);
        wait_ready();
        cmd(8'h70); rd_expect(8'h41, "R12 erase fails when protected");
        wp_n = 1'b1;

        // R11: identification
        cmd(8'h90); adr(8'h00);
        rd_expect(8'hEC, "R11 manufacturer code");
        rd_expect(8'h73, "R11 device code");

        // R13: reset aborts a spare program
        spare_hide = 1'b0;
        cmd(8'h50); cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h00); dat(8'h00); cmd(8'h10);
        repeat (3) @(negedge clk);
        cmd(8'hFF);
        wait_ready();
        adr(8'h00); adr(8'h00); adr(8'h00); wait_ready();
        rd_expect(8'h99, "R13 pointer back to low half");
        rd_addr(8'h50, 8'h00, 8'h00); rd_expect(8'hFF, "R13 aborted program left cells");
        cmd(8'h70); rd_expect(8'hC0, "R13 fail bit cleared");

        repeat (4) @(negedge clk);
        report();
    end
endmodule